// File: doc/BRIEF.md
# Serial Video Lock Detect Controller

This block decides whether a serial digital video receiver is locked to its incoming stream. It watches an active-low carrier-detect input, the lock flag of the clock recovery loop and single-cycle sync-found pulses from two word aligners: one for SMPTE timing reference words and one for DVB-ASI comma words. From these it drives a registered `locked` indication, a mute enable for the parallel data outputs and a command that recentres the reclocker frequency.

With a good carrier present the controller hunts for sync. The hunt is split into four windows of `WIN_CYC` cycles each. A sync pulse seen while the loop reports lock ends the hunt at once and declares lock. Four empty windows produce a single-cycle recentre pulse, after which the hunt starts over. Once locked, the block falls back to hunting if the loop loses lock or if no sync word arrives for `TMO_CYC` cycles. A lost carrier overrides everything: the block holds the reclocker at centre, drops `locked` and mutes the data outputs, except in DVB-ASI mode, where the data outputs keep running. In data-through mode sync detection is switched off and `locked` simply reports the loop lock flag. The parallel clock is never muted; the mute enable applies to data outputs only.

Top module: `vlock_ctrl`

## Requirements
- R1: During and directly after reset, `locked` is 0, `mute` is 1 and `recentre` is 1.
- R2: When `sig_absent` (carrier-detect, active low: 1 means no valid input) is 1 at a clock edge, from that edge on `locked` is 0 and `recentre` is 1, and `mute` is 1 unless `asi_mode` is 1.
- R3: With `asi_mode` = 1, `mute` is 0 after every edge, including while `sig_absent` is 1; `locked` is still 0 while the carrier is absent.
- R4: While hunting with `thru_mode` = 0, a cycle in which `trs_hit` or `asi_hit` is 1 and `pll_ok` is 1 makes `locked` go to 1 at the next edge.
- R5: A sync pulse while `pll_ok` is 0 does not set `locked`.
- R6: After the carrier becomes valid with no qualifying sync, `recentre` goes high for exactly one cycle after 4*`WIN_CYC`+1 edges (counted from the edge that first samples `sig_absent` = 0), then the hunt restarts and repeats with the same period.
- R7: While locked, if no sync pulse arrives for `TMO_CYC` consecutive cycles, `locked` goes to 0 on the `TMO_CYC`-th edge after the last sync or lock; a sync pulse restarts that count.
- R8: If `pll_ok` is 0 in a cycle, `locked` is 0 after the following edge.
- R9: With `thru_mode` = 1 and the carrier valid, `locked` equals the value `pll_ok` had one cycle earlier, and sync pulses have no effect on it.
- R10: `mute` is a register; it rises only at an edge where `locked` is also 0, so the data outputs go silent in the same cycle that lock is reported lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word-rate clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sig_absent | input | 1 | Carrier-detect, active low: 1 means no valid serial input |
| pll_ok | input | 1 | Clock recovery loop lock flag |
| trs_hit | input | 1 | One-cycle pulse: SMPTE timing reference word found |
| asi_hit | input | 1 | One-cycle pulse: DVB-ASI sync word found |
| thru_mode | input | 1 | Data-through mode, sync detection disabled |
| asi_mode | input | 1 | DVB-ASI mode, no data muting on carrier loss |
| locked | output | 1 | Registered lock indication |
| mute | output | 1 | Registered mute enable for the parallel data outputs |
| recentre | output | 1 | Command to set the reclocker to the centre of its pull range |

## Verification
The assertions take for granted that every input is synchronous to `clk` and settled before each edge, and that `WIN_CYC` is at least 2 so a window never ends in the cycle right after a recentre pulse. The bench drives all inputs on the falling edge and samples outputs on the next falling edge, and random stimulus is drawn with biased probabilities so that carrier loss, loop-lock drops and mode changes stay rare next to sync pulses, which lets hunts, locks, timeouts and recentre pulses all occur in one run.

// File: rtl/vlock_ctrl.sv
module vlock_ctrl #(
  parameter int WIN_CYC = 1024,
  parameter int TMO_CYC = 4096,
  parameter int N_TRY   = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sig_absent,
  input  logic pll_ok,
  input  logic trs_hit,
  input  logic asi_hit,
  input  logic thru_mode,
  input  logic asi_mode,
  output logic locked,
  output logic mute,
  output logic recentre
);
  localparam int WW = (WIN_CYC > 2) ? $clog2(WIN_CYC) : 1;
  localparam int TW = (TMO_CYC > 2) ? $clog2(TMO_CYC) : 1;
  localparam int AW = (N_TRY > 2) ? $clog2(N_TRY) : 1;

  typedef enum logic [1:0] {S_NOCAR, S_HUNT, S_LOCK} st_t;

  st_t           st, nst;
  logic [WW-1:0] wcnt;
  logic [TW-1:0] tcnt;
  logic [AW-1:0] tries;

  wire hit      = trs_hit | asi_hit;
  wire win_end  = wcnt == WW'(WIN_CYC - 1);
  wire last_try = tries == AW'(N_TRY - 1);
  wire tmo_end  = tcnt == TW'(TMO_CYC - 1);
  wire hunt_ok  = !thru_mode && hit && pll_ok;
  wire fail     = (st == S_HUNT) && !sig_absent && !thru_mode && !hunt_ok
                  && win_end && last_try;

  always_comb begin
    nst = st;
    if (sig_absent) nst = S_NOCAR;
    else begin
      case (st)
        S_NOCAR: nst = S_HUNT;
        S_HUNT:  if (hunt_ok) nst = S_LOCK;
        S_LOCK:  if (thru_mode || !pll_ok || (!hit && tmo_end)) nst = S_HUNT;
        default: nst = S_NOCAR;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_NOCAR;
      wcnt     <= '0;
      tries    <= '0;
      tcnt     <= '0;
      locked   <= 1'b0;
      mute     <= 1'b1;
      recentre <= 1'b1;
    end else begin
      st <= nst;
      if (st != S_HUNT || nst != S_HUNT || thru_mode) begin
        wcnt  <= '0;
        tries <= '0;
      end else if (win_end) begin
        wcnt  <= '0;
        tries <= last_try ? '0 : tries + 1'b1;
      end else begin
        wcnt <= wcnt + 1'b1;
      end
      if (st != S_LOCK || nst != S_LOCK || hit) tcnt <= '0;
      else                                       tcnt <= tcnt + 1'b1;
      locked   <= thru_mode ? (nst != S_NOCAR && pll_ok) : (nst == S_LOCK);
      mute     <= (nst == S_NOCAR) && !asi_mode;
      recentre <= (nst == S_NOCAR) || fail;
    end
  end

  AST_NOCAR_UNLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    sig_absent |=> !locked && recentre); // R2
  AST_NOCAR_MUTE: assert property (@(posedge clk) disable iff (!rst_n)
    sig_absent && !asi_mode |=> mute); // R2
  AST_ASI_NOMUTE: assert property (@(posedge clk) disable iff (!rst_n)
    asi_mode |=> !mute); // R3
  AST_PLL_GATES_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    !pll_ok |=> !locked); // R8
  AST_RECENTRE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    recentre && st == S_HUNT && !sig_absent |=> !recentre); // R6
  AST_THRU_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    thru_mode && !sig_absent |=> locked == $past(pll_ok)); // R9
  AST_MUTE_WITH_UNLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mute) |-> !locked); // R10
endmodule

// File: tb/sim_vlock_ctrl.sv
`timescale 1ns/1ps
module sim_vlock_ctrl;
  localparam int WIN = 8;
  localparam int TMO = 20;
  localparam int NT  = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sig_absent = 1'b1, pll_ok = 1'b0, trs_hit = 1'b0, asi_hit = 1'b0;
  logic thru_mode = 1'b0, asi_mode = 1'b0;
  logic locked, mute, recentre;
  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  vlock_ctrl #(.WIN_CYC(WIN), .TMO_CYC(TMO), .N_TRY(NT)) u0 (
    .clk(clk), .rst_n(rst_n), .sig_absent(sig_absent), .pll_ok(pll_ok),
    .trs_hit(trs_hit), .asi_hit(asi_hit), .thru_mode(thru_mode),
    .asi_mode(asi_mode), .locked(locked), .mute(mute), .recentre(recentre));

  // behavioural expectation built from the requirements
  int m_st, m_w, m_t, m_to;
  logic m_lk, m_mu, m_rc;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st <= 0; m_w <= 0; m_t <= 0; m_to <= 0;
      m_lk <= 0; m_mu <= 1; m_rc <= 1;
    end else begin : step
      int ns; bit h, fl;
      h = trs_hit | asi_hit;
      fl = 0;
      ns = m_st;
      if (sig_absent) ns = 0;
      else if (m_st == 0) ns = 1;
      else if (m_st == 1) begin
        if (!thru_mode && h && pll_ok) ns = 2;
        else if (!thru_mode && m_w == WIN-1 && m_t == NT-1) fl = 1;
      end else if (thru_mode || !pll_ok || (!h && m_to == TMO-1)) ns = 1;
      if (m_st != 1 || ns != 1 || thru_mode) begin m_w <= 0; m_t <= 0; end
      else if (m_w == WIN-1) begin m_w <= 0; m_t <= (m_t + 1) % NT; end
      else m_w <= m_w + 1;
      m_to <= (m_st != 2 || ns != 2 || h) ? 0 : m_to + 1;
      m_st <= ns;
      m_lk <= thru_mode ? (ns != 0 && pll_ok) : (ns == 2);
      m_mu <= ns == 0 && !asi_mode;
      m_rc <= ns == 0 || fl;
    end
  end

  function automatic bit agree(input logic a, input logic b);
    return a === b;
  endfunction

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int n;
    void'($urandom(32'd20240611));
    tick(2);
    chk("R1 locked", locked, 0); chk("R1 mute", mute, 1); chk("R1 recentre", recentre, 1);
    rst_n = 1'b1; tick(1);
    chk("R1 locked after reset", locked, 0);

    // R6: four empty windows
    sig_absent = 0; pll_ok = 1;
    n = 0;
    for (int i = 1; i <= 100; i++) begin
      tick(1);
      if (recentre) begin n = i; break; end
    end
    checks++;
    if (n != 4*WIN+1) begin fails++; $display("FAIL R6 edges actual=%0d expected=%0d", n, 4*WIN+1); end
    tick(1); chk("R6 single pulse", recentre, 0);

    // R5: sync without loop lock
    pll_ok = 0; trs_hit = 1; tick(1); trs_hit = 0;
    chk("R5 no lock without pll", locked, 0);

    // R4: lock on qualified sync
    pll_ok = 1; asi_hit = 1; tick(1); asi_hit = 0;
    chk("R4 lock on asi sync", locked, 1);

    // R7: sync timeout
    tick(TMO-1); chk("R7 still locked", locked, 1);
    tick(1);     chk("R7 timeout unlock", locked, 0);
    trs_hit = 1; tick(1); trs_hit = 0;
    chk("R4 lock on trs sync", locked, 1);
    tick(TMO-3); trs_hit = 1; tick(1); trs_hit = 0;
    tick(TMO-1); chk("R7 sync restarts timeout", locked, 1);

    // R8: loop lock drop
    pll_ok = 0; tick(1); chk("R8 unlock on pll drop", locked, 0);
    pll_ok = 1; trs_hit = 1; tick(1); trs_hit = 0;
    chk("R4 relock", locked, 1);

    // R2 / R10: carrier loss
    sig_absent = 1; tick(1);
    chk("R2 locked", locked, 0); chk("R2 recentre", recentre, 1);
    chk("R10 mute with unlock", mute, 1);

    // R3: DVB-ASI mode
    asi_mode = 1; tick(1);
    chk("R3 no mute", mute, 0); chk("R3 locked low", locked, 0);
    asi_mode = 0; sig_absent = 0;

    // R9: data-through
    thru_mode = 1; pll_ok = 1; tick(2);
    chk("R9 follows pll high", locked, 1);
    pll_ok = 0; tick(1); chk("R9 follows pll low", locked, 0);
    trs_hit = 1; asi_hit = 1; tick(1); trs_hit = 0; asi_hit = 0;
    chk("R9 sync ignored", locked, 0);
    thru_mode = 0; pll_ok = 1;

    // constrained random against the expectation
    rst_n = 0; sig_absent = 1; tick(2); rst_n = 1;
    for (int c = 0; c < 4000; c++) begin
      tick(1);
      if (!agree(locked, m_lk)) chk("R4,R7,R8 random locked", locked, m_lk);
      else checks++;
      if (!agree(mute, m_mu)) chk("R2,R3 random mute", mute, m_mu);
      else checks++;
      if (!agree(recentre, m_rc)) chk("R6 random recentre", recentre, m_rc);
      else checks++;
      if (sig_absent) sig_absent = ($urandom % 6 != 0);
      else            sig_absent = ($urandom % 150 == 0);
      if (pll_ok) pll_ok = ($urandom % 40 != 0);
      else        pll_ok = ($urandom % 4 == 0);
      trs_hit = ($urandom % 12 == 0);
      asi_hit = ($urandom % 25 == 0);
      if ($urandom % 500 == 0) thru_mode = !thru_mode;
      if ($urandom % 400 == 0) asi_mode = !asi_mode;
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule